// File: doc/BRIEF.md
# Parallel Flash Programming Host

This block drives a byte-wide asynchronous flash bus from the host side. A request carries an operation (byte program, whole-chip erase or single read), a target address and a data byte. For program and erase it sends the fixed unlock-and-command write cycles, then polls the target location until the top data bit shows the final value. It then returns the result on a response port.

Every bus cycle follows time limits given in nanoseconds. These limits become clock-cycle counts through a clock-period parameter. The host drives the data lines only during its own write cycles. A separate output-enable pin for the data lines lets the pad logic release them during every read.

Requests use valid/ready. `req_ready` is high only when the block is idle and no response is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Responses also use valid/ready. When `resp_valid` is high, the response stays put until the consumer raises `resp_ready`, and no new request is taken until then. This is the only back-pressure path.

Top module: `pflash_host`

## Requirements
- R1: `req_ready` is high only in the idle state with no response pending. A request is taken only on an edge where `req_valid` and `req_ready` are both high. A request offered while the block is busy starts no bus activity.
- R2: A program request (`req_op` = 2'b01) issues exactly four write cycles, in this order: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then the request data at the request address.
- R3: An erase request (`req_op` = 2'b10) issues exactly six write cycles, in this order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h.
- R4: In every write cycle, chip enable is low and output enable is high. Address and data are stable across the falling and the rising edge of write enable. Write enable stays low for at least the low-pulse time (90 ns by default) and at least the data-setup time. It stays high for at least the high-pulse time (90 ns) between falls.
- R5: The host drives the data lines (`flash_dq_oe` = 1) only during write cycles, and never while output enable is low.
- R6: A read cycle holds chip enable and output enable low with write enable high. It samples the data lines no earlier than the access time (70 ns by default) after address and enables are applied.
- R7: After the last write of a program or erase, the block reads the target address until data bit 7 equals the expected value: bit 7 of the request data for program, 1 for erase. It then does one more read and returns that byte with `resp_timeout` = 0.
- R8: If `MAX_POLLS` polling reads all mismatch, the block stops polling and responds with `resp_timeout` = 1 after exactly `MAX_POLLS` reads.
- R9: A read request (`req_op` = 2'b00, and the unused code 2'b11) performs one read cycle at the request address and no write cycle. It returns the byte read with `resp_timeout` = 0.
- R10: While `resp_valid` is high and `resp_ready` is low, `resp_valid`, `resp_data` and `resp_timeout` hold their values.
- R11: During and right after reset, chip enable, output enable and write enable are high, `flash_dq_oe` is 0, `resp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 read |
| req_addr | input | ADDR_W | Target address |
| req_data | input | DATA_W | Byte to program |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Response consumed |
| resp_data | output | DATA_W | Byte read (final read of the operation) |
| resp_timeout | output | 1 | Polling limit reached |
| flash_addr | output | ADDR_W | Flash address lines |
| flash_dq_o | output | DATA_W | Data to flash |
| flash_dq_oe | output | 1 | Enable for the host's data drivers |
| flash_dq_i | input | DATA_W | Data from flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |

## Verification
The hardest cases to reach from the ports are the polling limit and a transient read in which bit 7 already shows the final value but the other bits do not. Neither occurs with a flash that simply finishes.

The bench's behavioural flash counts reads while it is busy. It can stay busy for a chosen number of reads or indefinitely, and it can return one transient byte when busy ends. This makes the poll count and the confirming read observable as an exact number of output-enable pulses and a returned byte.

The model also answers reads only after the access time, so a host that samples too early gets a wrong byte.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_PROGRAM = 2'b01,
    OP_ERASE   = 2'b10,
    OP_RSVD    = 2'b11
  } pf_op_e;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_FIRST     = 8'hAA;
  localparam logic [7:0]  KEY_SECOND    = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM   = 8'hA0;
  localparam logic [7:0]  CMD_ERASE_ARM = 8'h80;
  localparam logic [7:0]  CMD_ERASE_ALL = 8'h10;

  localparam int unsigned PROGRAM_STEPS = 4;
  localparam int unsigned ERASE_STEPS   = 6;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
  import pflash_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STEP_W = 3
) (
  input  pf_op_e            op,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(UNLOCK_ADDR_A);
  localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(UNLOCK_ADDR_B);

  logic is_prog;
  assign is_prog = (op == OP_PROGRAM);

  always_comb begin
    cyc_addr = ADDR_A;
    cyc_data = DATA_W'(KEY_FIRST);
    case (step)
      STEP_W'(0): begin
        cyc_addr = ADDR_A;
        cyc_data = DATA_W'(KEY_FIRST);
      end
      STEP_W'(1), STEP_W'(4): begin
        cyc_addr = ADDR_B;
        cyc_data = DATA_W'(KEY_SECOND);
      end
      STEP_W'(2): begin
        cyc_addr = ADDR_A;
        cyc_data = is_prog ? DATA_W'(CMD_PROGRAM) : DATA_W'(CMD_ERASE_ARM);
      end
      STEP_W'(3): begin
        cyc_addr = is_prog ? tgt_addr : ADDR_A;
        cyc_data = is_prog ? tgt_data : DATA_W'(KEY_FIRST);
      end
      STEP_W'(5): begin
        cyc_addr = ADDR_A;
        cyc_data = DATA_W'(CMD_ERASE_ALL);
      end
      default: begin
        cyc_addr = ADDR_A;
        cyc_data = DATA_W'(KEY_FIRST);
      end
    endcase
  end

  assign last = is_prog ? (step == STEP_W'(PROGRAM_STEPS - 1))
                        : (step == STEP_W'(ERASE_STEPS - 1));

endmodule

// File: rtl/pflash_bus_cycle.sv
module pflash_bus_cycle #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOW_CYC  = 23,
  parameter int unsigned HIGH_CYC = 23,
  parameter int unsigned ACC_CYC  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_dq_oe,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n
);

  localparam int unsigned MAX_CYC = (LOW_CYC > HIGH_CYC) ?
                                    ((LOW_CYC > ACC_CYC) ? LOW_CYC : ACC_CYC) :
                                    ((HIGH_CYC > ACC_CYC) ? HIGH_CYC : ACC_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {E_IDLE, E_SETUP, E_LOW, E_READ, E_HIGH} eng_st_e;

  eng_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
      rdata  <= '0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          addr_q <= addr_in;
          data_q <= data_in;
          rd_q   <= is_read;
          if (is_read) begin
            st  <= E_READ;
            cnt <= CNT_W'(ACC_CYC - 1);
          end else begin
            st  <= E_SETUP;
          end
        end
        E_SETUP: begin
          st  <= E_LOW;
          cnt <= CNT_W'(LOW_CYC - 1);
        end
        E_LOW: begin
          if (cnt_zero) begin
            st  <= E_HIGH;
            cnt <= CNT_W'(HIGH_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_READ: begin
          if (cnt_zero) begin
            rdata <= flash_dq_i;
            st    <= E_HIGH;
            cnt   <= CNT_W'(HIGH_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        E_HIGH: begin
          if (cnt_zero) st <= E_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  logic wr_active;
  assign wr_active   = !rd_q && (st == E_SETUP || st == E_LOW || st == E_HIGH);
  assign done        = (st == E_HIGH) && cnt_zero;
  assign flash_addr  = addr_q;
  assign flash_dq_o  = data_q;
  assign flash_dq_oe = wr_active;
  assign flash_ce_n  = !(wr_active || st == E_READ);
  assign flash_oe_n  = (st != E_READ);
  assign flash_we_n  = (st != E_LOW);

  // Pulse-width observers for the checks below
  localparam int unsigned RUN_W = $clog2(MAX_CYC + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MAX_CYC + 1);
  logic [RUN_W-1:0] lo_run, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= RUN_SAT;
    end else if (!flash_we_n) begin
      lo_run <= (lo_run == RUN_SAT) ? lo_run : lo_run + 1'b1;
      hi_run <= '0;
    end else begin
      hi_run <= (hi_run == RUN_SAT) ? hi_run : hi_run + 1'b1;
      lo_run <= '0;
    end
  end

  // R4
  we_fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_we_n) |-> $stable(flash_addr) && $stable(flash_dq_o) && flash_oe_n && !flash_ce_n);
  // R4
  we_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> $stable(flash_addr) && $stable(flash_dq_o) && !flash_ce_n);
  // R4
  we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> lo_run >= RUN_W'(LOW_CYC));
  // R4
  we_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_we_n) |-> hi_run >= RUN_W'(HIGH_CYC));
  // R5
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_dq_oe |-> flash_oe_n);
  // R6
  read_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n |-> flash_we_n && !flash_ce_n);

endmodule

// File: rtl/pflash_host.sv
module pflash_host
  import pflash_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_NS        = 4,
  parameter int unsigned WE_LOW_NS     = 90,
  parameter int unsigned WE_HIGH_NS    = 90,
  parameter int unsigned DATA_SETUP_NS = 50,
  parameter int unsigned ADDR_HOLD_NS  = 50,
  parameter int unsigned ACCESS_NS     = 70,
  parameter int unsigned MAX_POLLS     = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_timeout,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_dq_oe,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n
);

  localparam int unsigned LOW_CYC  = max_u(max_u(ns_to_cyc(WE_LOW_NS, CLK_NS),
                                                 ns_to_cyc(DATA_SETUP_NS, CLK_NS)),
                                           max_u(ns_to_cyc(ADDR_HOLD_NS, CLK_NS), 1));
  localparam int unsigned HIGH_CYC = max_u(ns_to_cyc(WE_HIGH_NS, CLK_NS), 1);
  localparam int unsigned ACC_CYC  = max_u(ns_to_cyc(ACCESS_NS, CLK_NS), 1);
  localparam int unsigned STEP_W   = $clog2(ERASE_STEPS);
  localparam int unsigned POLL_W   = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    T_IDLE, T_WR, T_WR_WAIT, T_POLL, T_POLL_WAIT, T_CONF, T_CONF_WAIT, T_RESP
  } host_st_e;

  host_st_e          st;
  pf_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STEP_W-1:0] step_q;
  logic [POLL_W-1:0] poll_cnt;

  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_data;
  logic              seq_last;
  logic              eng_start, eng_is_read, eng_done;
  logic [DATA_W-1:0] eng_rdata;
  logic              exp_msb;

  pflash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_seq (
    .op       (op_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .cyc_addr (seq_addr),
    .cyc_data (seq_data),
    .last     (seq_last)
  );

  assign eng_start   = (st == T_WR) || (st == T_POLL) || (st == T_CONF);
  assign eng_is_read = (st != T_WR);

  pflash_bus_cycle #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .ACC_CYC(ACC_CYC)
  ) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (eng_start),
    .is_read     (eng_is_read),
    .addr_in     ((st == T_WR) ? seq_addr : addr_q),
    .data_in     (seq_data),
    .done        (eng_done),
    .rdata       (eng_rdata),
    .flash_addr  (flash_addr),
    .flash_dq_o  (flash_dq_o),
    .flash_dq_oe (flash_dq_oe),
    .flash_dq_i  (flash_dq_i),
    .flash_ce_n  (flash_ce_n),
    .flash_oe_n  (flash_oe_n),
    .flash_we_n  (flash_we_n)
  );

  assign exp_msb   = (op_q == OP_ERASE) ? 1'b1 : data_q[DATA_W-1];
  assign req_ready = (st == T_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= T_IDLE;
      op_q         <= OP_READ;
      addr_q       <= '0;
      data_q       <= '0;
      step_q       <= '0;
      poll_cnt     <= '0;
      resp_valid   <= 1'b0;
      resp_data    <= '0;
      resp_timeout <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (req_valid) begin
          op_q     <= pf_op_e'(req_op);
          addr_q   <= req_addr;
          data_q   <= req_data;
          step_q   <= '0;
          poll_cnt <= '0;
          if (pf_op_e'(req_op) == OP_PROGRAM || pf_op_e'(req_op) == OP_ERASE) st <= T_WR;
          else                                                                st <= T_CONF;
        end
        T_WR:   st <= T_WR_WAIT;
        T_WR_WAIT: if (eng_done) begin
          if (seq_last) begin
            st <= T_POLL;
          end else begin
            step_q <= step_q + 1'b1;
            st     <= T_WR;
          end
        end
        T_POLL: st <= T_POLL_WAIT;
        T_POLL_WAIT: if (eng_done) begin
          if (eng_rdata[DATA_W-1] == exp_msb) begin
            st <= T_CONF;
          end else if (poll_cnt == POLL_W'(MAX_POLLS - 1)) begin
            resp_data    <= eng_rdata;
            resp_timeout <= 1'b1;
            resp_valid   <= 1'b1;
            st           <= T_RESP;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            st       <= T_POLL;
          end
        end
        T_CONF: st <= T_CONF_WAIT;
        T_CONF_WAIT: if (eng_done) begin
          resp_data    <= eng_rdata;
          resp_timeout <= 1'b0;
          resp_valid   <= 1'b1;
          st           <= T_RESP;
        end
        T_RESP: if (resp_ready) begin
          resp_valid <= 1'b0;
          st         <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R1
  ready_excl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !resp_valid);
  // R1
  no_bus_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> flash_ce_n);
  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < POLL_W'(MAX_POLLS));
  // R10
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data) && $stable(resp_timeout));

endmodule

// File: tb/pflash_host_bench.sv
`timescale 1ns/1ps
module pflash_host_bench;

  localparam int MAXP = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [7:0]  resp_data;
  logic        resp_timeout;
  logic [18:0] flash_addr;
  logic [7:0]  flash_dq_o;
  logic        flash_dq_oe;
  logic [7:0]  flash_dq_i = 8'h00;
  logic        flash_ce_n, flash_oe_n, flash_we_n;

  always #2 clk = ~clk;

  pflash_host #(.MAX_POLLS(MAXP)) u_pflash_host (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .resp_timeout(resp_timeout),
    .flash_addr(flash_addr), .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
    .flash_dq_i(flash_dq_i), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .flash_we_n(flash_we_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input string rq, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- behavioural flash ----------------
  logic [7:0]  mem [64];
  int          seq_st = 0;
  bit          busy = 0, stuck = 0, glitch = 0, tog = 0;
  logic [7:0]  busy_data = 8'hFF;
  int          busy_left = 0;
  int          n_wr = 0, n_rd = 0, n_viol = 0;
  logic [18:0] log_a [16];
  logic [7:0]  log_d [16];
  logic [18:0] fall_addr = '0;
  realtime     t_fall = 0, t_rise = -1000, t_dq = -1000;

  initial for (int i = 0; i < 64; i++) mem[i] = 8'hFF;

  task automatic bad_seq();
    n_viol++;
    seq_st = 0;
  endtask

  task automatic decode(input logic [18:0] a, input logic [7:0] d);
    case (seq_st)
      0: if (a == 19'h05555 && d == 8'hAA) seq_st = 1; else bad_seq();
      1: if (a == 19'h02AAA && d == 8'h55) seq_st = 2; else bad_seq();
      2: if (a == 19'h05555 && d == 8'hA0) seq_st = 3;
         else if (a == 19'h05555 && d == 8'h80) seq_st = 4;
         else bad_seq();
      3: begin
        mem[a[5:0]] = mem[a[5:0]] & d;
        busy_data = d; busy = 1; seq_st = 0;
      end
      4: if (a == 19'h05555 && d == 8'hAA) seq_st = 5; else bad_seq();
      5: if (a == 19'h02AAA && d == 8'h55) seq_st = 6; else bad_seq();
      6: if (a == 19'h05555 && d == 8'h10) begin
           for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
           busy_data = 8'hFF; busy = 1; seq_st = 0;
         end else bad_seq();
      default: bad_seq();
    endcase
  endtask

  always @(flash_dq_o) t_dq = $realtime;
  always @(flash_addr) if (rst_n && !flash_we_n) n_viol++;
  always @(negedge clk) if (rst_n && flash_dq_oe && !flash_oe_n) n_viol++;

  always @(negedge flash_we_n) if (rst_n && !flash_ce_n) begin
    if (!flash_oe_n) n_viol++;
    if ($realtime - t_rise < 90.0) n_viol++;
    fall_addr = flash_addr;
    t_fall = $realtime;
  end

  always @(posedge flash_we_n) if (rst_n && !flash_ce_n) begin
    if ($realtime - t_fall < 90.0) n_viol++;
    if ($realtime - t_dq < 50.0) n_viol++;
    if (flash_addr != fall_addr) n_viol++;
    t_rise = $realtime;
    if (n_wr < 16) begin
      log_a[n_wr] = fall_addr;
      log_d[n_wr] = flash_dq_o;
    end
    n_wr++;
    decode(fall_addr, flash_dq_o);
  end

  always @(negedge flash_oe_n) if (rst_n && !flash_ce_n) begin
    logic [7:0] val;
    if (!flash_we_n) n_viol++;
    n_rd++;
    if (busy && (stuck || busy_left > 0)) begin
      tog = ~tog;
      val = {~busy_data[7], tog, 6'h15};
      busy_left--;
    end else begin
      busy = 0;
      if (glitch) begin
        val = {mem[flash_addr[5:0]][7], ~mem[flash_addr[5:0]][6:0]};
        glitch = 0;
      end else begin
        val = mem[flash_addr[5:0]];
      end
    end
    flash_dq_i = 8'h5A;
    #70;
    flash_dq_i = val;
  end

  // ---------------- helpers ----------------
  task automatic clear_counts();
    n_wr = 0;
    n_rd = 0;
  endtask

  task automatic send_req(input logic [1:0] op, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic take_resp(output logic [7:0] r, output logic e);
    while (!resp_valid) @(negedge clk);
    r = resp_data;
    e = resp_timeout;
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R11 ce_n", flash_ce_n, 1);
    chk("R11 oe_n", flash_oe_n, 1);
    chk("R11 we_n", flash_we_n, 1);
    chk("R11 dq_oe", flash_dq_oe, 0);
    chk("R11 resp_valid", resp_valid, 0);
    chk("R11 req_ready", req_ready, 1);
  endtask

  task automatic t_erase();
    logic [7:0] r; logic e;
    logic [18:0] ea [6] = '{19'h05555, 19'h02AAA, 19'h05555, 19'h05555, 19'h02AAA, 19'h05555};
    logic [7:0]  ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    clear_counts(); busy_left = 2;
    send_req(2'b10, 19'h00100, 8'h00);
    take_resp(r, e);
    chk("R3 erase write count", n_wr, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R3 erase addr", log_a[i], ea[i]);
      chk("R3 erase data", log_d[i], ed[i]);
    end
    chk("R7 erase poll reads", n_rd, 4);
    chk("R7 erase data", r, 8'hFF);
    chk("R7 erase timeout flag", e, 0);
  endtask

  task automatic t_program_hi();
    logic [7:0] r; logic e;
    clear_counts(); busy_left = 3;
    send_req(2'b01, 19'h12345, 8'hA5);
    chk("R1 ready low while busy", req_ready, 0);
    take_resp(r, e);
    chk("R2 program write count", n_wr, 4);
    chk("R2 step0 addr", log_a[0], 19'h05555); chk("R2 step0 data", log_d[0], 8'hAA);
    chk("R2 step1 addr", log_a[1], 19'h02AAA); chk("R2 step1 data", log_d[1], 8'h55);
    chk("R2 step2 addr", log_a[2], 19'h05555); chk("R2 step2 data", log_d[2], 8'hA0);
    chk("R2 step3 addr", log_a[3], 19'h12345); chk("R2 step3 data", log_d[3], 8'hA5);
    chk("R7 program poll reads", n_rd, 5);
    chk("R7 program data", r, 8'hA5);
    chk("R7 program timeout flag", e, 0);
  endtask

  task automatic t_read();
    logic [7:0] r; logic e;
    clear_counts();
    send_req(2'b00, 19'h12345, 8'h00);
    take_resp(r, e);
    chk("R9 read data", r, 8'hA5);
    chk("R9 read writes", n_wr, 0);
    chk("R6 read cycles", n_rd, 1);
    clear_counts();
    send_req(2'b11, 19'h12345, 8'h00);
    take_resp(r, e);
    chk("R9 code 11 data", r, 8'hA5);
    chk("R9 code 11 writes", n_wr, 0);
  endtask

  task automatic t_program_lo();
    logic [7:0] r; logic e;
    clear_counts(); busy_left = 0;
    send_req(2'b01, 19'h00007, 8'h3C);
    take_resp(r, e);
    chk("R7 msb0 poll reads", n_rd, 2);
    chk("R7 msb0 data", r, 8'h3C);
  endtask

  task automatic t_glitch();
    logic [7:0] r; logic e;
    clear_counts(); busy_left = 2; glitch = 1;
    send_req(2'b01, 19'h00021, 8'h96);
    take_resp(r, e);
    chk("R7 confirm read data", r, 8'h96);
    chk("R7 confirm read count", n_rd, 4);
  endtask

  task automatic t_timeout();
    logic [7:0] r; logic e;
    clear_counts(); stuck = 1;
    send_req(2'b01, 19'h00002, 8'h11);
    take_resp(r, e);
    chk("R8 timeout flag", e, 1);
    chk("R8 poll reads", n_rd, MAXP);
    stuck = 0; busy = 0;
  endtask

  task automatic t_backpressure();
    logic [7:0] r; logic e;
    clear_counts();
    send_req(2'b00, 19'h12345, 8'h00);
    while (!resp_valid) @(negedge clk);
    req_valid = 1; req_op = 2'b00; req_addr = 19'h00021;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!resp_valid || resp_data != 8'hA5 || req_ready) begin
        chk("R10 held response", {resp_valid, resp_data, req_ready}, {1'b1, 8'hA5, 1'b0});
      end
    end
    chk("R10 data after stall", resp_data, 8'hA5);
    chk("R1 no read taken while response pending", n_rd, 1);
    req_valid = 0;
    take_resp(r, e);
    chk("R10 taken data", r, 8'hA5);
    repeat (60) @(negedge clk);
    chk("R1 withdrawn request ignored", n_rd, 1);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_erase();
    t_program_hi();
    t_read();
    t_program_lo();
    t_glitch();
    t_timeout();
    t_backpressure();
    chk("R4 R5 bus timing violations", n_viol, 0);
    finish_run();
  end

endmodule